// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block is a synthesizable model of a synchronous static RAM. Its data bus can switch from reads to writes, and back, on every clock cycle with no idle cycle between them. Address, chip enables, read/write control and byte enables are all captured on the rising clock edge. The write data for an access arrives some cycles after its address, so the shared bus sees read data and write data in the same order as the commands that asked for them.

A static mode input selects one of two read timings. In flow-through timing the read word is driven in the cycle right after the capturing edge, and write data follows its address by one cycle. In pipelined timing an output register adds one more cycle to reads, and write data follows its address by two cycles. An internal sequencer produces four-beat bursts in linear or interleaved order from a single start address. An asynchronous output enable and an asynchronous sleep input can switch the outputs off at any time. The tri-state data pins are modelled as a data bus plus a drive-enable flag.

Top module: `nowait_sram`

## Requirements
- R1: A command is accepted only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. With any one of them inactive, the edge starts no read and no write.
- R2: In flow-through mode (`pipe_mode`=0), a read captured at an edge drives `q_en`=1 and the stored word on `q_out` during the following clock cycle only.
- R3: In pipelined mode (`pipe_mode`=1), read data appears one edge later than in flow-through mode. In the cycle right after the capturing edge, `q_en` stays 0 for that read.
- R4: Write data on `d_in` is taken at the first edge after the address edge in flow-through mode, and at the second edge in pipelined mode. Deselected cycles in between do not cancel a write that is already scheduled.
- R5: Reads and writes may alternate on consecutive cycles in either mode, with no idle cycle, and every access gives its correct result.
- R6: In pipelined mode, a read of an address whose write data is still pending returns the new bytes, not the stale stored word.
- R7: `bw_n[i]`=0 at the address edge of a write enables lane i, bits [9i+8:9i]. Lanes with `bw_n[i]`=1 keep their stored value.
- R8: With `burst_ilv`=0, a cycle with `adv`=1 continues the current burst. The low two address bits of beat k are (start+k) mod 4, and the upper address bits and the read/write type stay those of the first beat.
- R9: With `burst_ilv`=1, the low two address bits of beat k are start XOR k.
- R10: `oe_n`=1 forces `q_en`=0 and `q_out`=0 at once, with no clock edge needed.
- R11: `sleep`=1 turns the outputs off at once. Edges seen while `sleep` is high capture no command and drop any scheduled write.
- R12: After reset, `q_en`=0 and no burst is open, so an `adv` cycle before any load performs no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pipe_mode | input | 1 | 1 = pipelined read timing, 0 = flow-through; static |
| burst_ilv | input | 1 | 1 = interleaved burst order, 0 = linear; static |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adv | input | 1 | 1 = continue the open burst instead of loading `addr` |
| we_n | input | 1 | 0 = write, 1 = read, for a loaded command |
| bw_n | input | LANES | Per-lane write enables, active low |
| addr | input | ADDR_W | Word address |
| d_in | input | LANES*BYTE_W | Late write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous power-down |
| q_en | output | 1 | 1 while the read data bus is driven |
| q_out | output | LANES*BYTE_W | Read data, zero when not driven |

## Verification
A flow-through read is due in the cycle that follows its capturing edge. A pipelined read is due one cycle after that. Write data has to be present one edge after its address in flow-through mode and two edges after it in pipelined mode. The bench drives every input at the falling edge, one command per task step. It supplies each write's data in the step that matches the mode, and it samples the outputs at the falling edge that follows the edge the result is due from. That is the next step for flow-through reads and the second step for pipelined reads. The asynchronous output enable and sleep are checked a short delay after they change, with no clock edge in between.

// File: rtl/nws_pkg.sv
// Shared definitions for the zero-turnaround SRAM model.
// Assumes bursts are always four beats, so the beat index is two bits wide.
package nws_pkg;
    localparam int BURST_LEN = 4;
    localparam int BEAT_W    = $clog2(BURST_LEN);

    // Low address bits of a burst beat, from the start offset and beat index.
    function automatic logic [BEAT_W-1:0] beat_offset(
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] beat,
        input logic              ilv
    );
        return ilv ? (start ^ beat) : (start + beat);
    endfunction
endpackage

// File: rtl/nws_burst_seq.sv
// Burst address sequencer: turns each selected cycle into one access.
// A loaded cycle passes the port address straight through. An advance cycle
// produces the next beat of the open burst and keeps its read/write type.
// Assumes ADDR_W > 2 and a burst_ilv input that does not change.
module nws_burst_seq
    import nws_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ilv,
    input  logic              sel,
    input  logic              adv,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              op_valid,
    output logic              op_write,
    output logic [ADDR_W-1:0] op_addr
);
    logic              active_q;
    logic              wr_q;
    logic [ADDR_W-1:0] base_q;
    logic [BEAT_W-1:0] beat_q;
    logic [BEAT_W-1:0] beat_nxt;
    logic              load;
    logic              cont;

    // Decide between a fresh load and a burst continuation for this cycle.
    always_comb begin
        load     = sel && !adv;
        cont     = sel && adv && active_q;
        beat_nxt = beat_q + 1'b1;
        op_valid = load || cont;
        op_write = load ? !we_n : wr_q;
        op_addr  = load ? addr
                        : {base_q[ADDR_W-1:BEAT_W],
                           beat_offset(base_q[BEAT_W-1:0], beat_nxt, ilv)};
    end

    // Hold the burst origin and step the beat index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            wr_q     <= 1'b0;
            base_q   <= '0;
            beat_q   <= '0;
        end else if (load) begin
            active_q <= 1'b1;
            wr_q     <= !we_n;
            base_q   <= addr;
            beat_q   <= '0;
        end else if (cont) begin
            beat_q   <= beat_nxt;
        end
    end
endmodule

// File: rtl/nws_write_pipe.sv
// Late-write scheduler: holds each write's address and lane enables until
// its data arrives. Stage 0 is committed in flow-through mode and the last
// stage in pipelined mode. A flush empties every stage.
// Assumes pipe_mode changes only while reset is held.
module nws_write_pipe #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pipe_mode,
    input  logic              flush,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]  req_be,
    output logic              cm_valid,
    output logic [ADDR_W-1:0] cm_addr,
    output logic [LANES-1:0]  cm_be
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] v_q;
    logic [ADDR_W-1:0] a_q  [STAGES];
    logic [LANES-1:0]  be_q [STAGES];

    // Capture a new write request into stage 0.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            v_q[0]  <= 1'b0;
            a_q[0]  <= '0;
            be_q[0] <= '0;
        end else begin
            v_q[0]  <= req;
            a_q[0]  <= req_addr;
            be_q[0] <= req_be;
        end
    end

    // Later stages move forward only in pipelined mode.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                v_q[s]  <= 1'b0;
                a_q[s]  <= '0;
                be_q[s] <= '0;
            end else begin
                v_q[s]  <= pipe_mode && v_q[s-1];
                a_q[s]  <= a_q[s-1];
                be_q[s] <= be_q[s-1];
            end
        end
    end

    // Pick the stage whose data is on the bus this cycle.
    always_comb begin
        cm_valid = pipe_mode ? v_q[LAST]  : v_q[0];
        cm_addr  = pipe_mode ? a_q[LAST]  : a_q[0];
        cm_be    = pipe_mode ? be_q[LAST] : be_q[0];
    end
endmodule

// File: rtl/nws_array.sv
// Storage array with lane-masked writes. Reads are asynchronous. A second
// read port merges the write under way this cycle over the stored word, so
// a register loaded at the same edge never sees stale bytes.
// The array has no reset and its contents are undefined until written.
module nws_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int BYTE_W = 9
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES-1:0]        wr_be,
    input  logic [LANES*BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*BYTE_W-1:0] rd_data,
    output logic [LANES*BYTE_W-1:0] fwd_data
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = LANES * BYTE_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic              hit;

    // Write the enabled lanes of the committing word.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int i = 0; i < LANES; i++) begin
                if (wr_be[i]) begin
                    mem[wr_addr][i*BYTE_W +: BYTE_W] <= wr_data[i*BYTE_W +: BYTE_W];
                end
            end
        end
    end

    // Read the stored word and flag a same-address commit.
    always_comb begin
        rd_data = mem[rd_addr];
        hit     = wr_en && (wr_addr == rd_addr);
    end

    // Merge each enabled pending lane over the stored lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            fwd_data[g*BYTE_W +: BYTE_W] = (hit && wr_be[g])
                ? wr_data[g*BYTE_W +: BYTE_W]
                : rd_data[g*BYTE_W +: BYTE_W];
        end
    end
endmodule

// File: rtl/nowait_sram.sv
// Top level of the zero-turnaround synchronous SRAM model.
// Combines the chip enables, runs the burst sequencer, schedules late writes,
// and presents read data either straight from the array (flow-through) or
// through an output register (pipelined). Output enable and sleep gate the
// outputs without waiting for a clock edge.
// Assumes pipe_mode and burst_ilv change only while reset is held.
module nowait_sram #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int BYTE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pipe_mode,
    input  logic                    burst_ilv,
    input  logic                    ce1_n,
    input  logic                    ce2,
    input  logic                    ce3_n,
    input  logic                    adv,
    input  logic                    we_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*BYTE_W-1:0] d_in,
    input  logic                    oe_n,
    input  logic                    sleep,
    output logic                    q_en,
    output logic [LANES*BYTE_W-1:0] q_out
);
    localparam int DATA_W = LANES * BYTE_W;

    logic              sel;
    logic              op_valid;
    logic              op_write;
    logic [ADDR_W-1:0] op_addr;
    logic              wr_req;
    logic              rd_req;
    logic              cm_valid;
    logic [ADDR_W-1:0] cm_addr;
    logic [LANES-1:0]  cm_be;
    logic              rd_v;
    logic [ADDR_W-1:0] rd_a;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] fwd_data;
    logic              out_v;
    logic [DATA_W-1:0] out_d;

    // Device is addressed only with all enables active and not asleep.
    always_comb begin
        sel    = !ce1_n && ce2 && !ce3_n && !sleep;
        wr_req = op_valid && op_write;
        rd_req = op_valid && !op_write;
    end

    nws_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ilv      (burst_ilv),
        .sel      (sel),
        .adv      (adv),
        .we_n     (we_n),
        .addr     (addr),
        .op_valid (op_valid),
        .op_write (op_write),
        .op_addr  (op_addr)
    );

    nws_write_pipe #(.ADDR_W(ADDR_W), .LANES(LANES), .STAGES(2)) u_wpipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .pipe_mode (pipe_mode),
        .flush     (sleep),
        .req       (wr_req),
        .req_addr  (op_addr),
        .req_be    (~bw_n),
        .cm_valid  (cm_valid),
        .cm_addr   (cm_addr),
        .cm_be     (cm_be)
    );

    nws_array #(.ADDR_W(ADDR_W), .LANES(LANES), .BYTE_W(BYTE_W)) u_array (
        .clk      (clk),
        .wr_en    (cm_valid),
        .wr_addr  (cm_addr),
        .wr_be    (cm_be),
        .wr_data  (d_in),
        .rd_addr  (rd_a),
        .rd_data  (rd_data),
        .fwd_data (fwd_data)
    );

    // Capture the read address of this cycle's access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_v <= 1'b0;
            rd_a <= '0;
        end else begin
            rd_v <= rd_req;
            if (rd_req) begin
                rd_a <= op_addr;
            end
        end
    end

    // Pipelined output register, loaded with pending bytes merged in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_v <= 1'b0;
            out_d <= '0;
        end else begin
            out_v <= rd_v && pipe_mode && !sleep;
            if (rd_v) begin
                out_d <= fwd_data;
            end
        end
    end

    // Drive the data bus, gated by output enable and sleep.
    always_comb begin
        q_en  = !oe_n && !sleep && (pipe_mode ? out_v : rd_v);
        q_out = q_en ? (pipe_mode ? out_d : rd_data) : '0;
    end
endmodule

// File: rtl/nws_checker.sv
// Property checker for nowait_sram, attached through bind.
// Watches ports and the signals passed between the sequencer, the write
// scheduler and the output stage.
module nws_checker #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pipe_mode,
    input logic              burst_ilv,
    input logic              ce1_n,
    input logic              ce2,
    input logic              ce3_n,
    input logic              adv,
    input logic              sleep,
    input logic              oe_n,
    input logic              q_en,
    input logic [DATA_W-1:0] q_out,
    input logic              op_valid,
    input logic              op_write,
    input logic [ADDR_W-1:0] op_addr,
    input logic              rd_v,
    input logic              out_v,
    input logic              cm_valid
);
    // A deselected cycle produces no access.
    always_comb begin
        if (rst_n && !(!ce1_n && ce2 && !ce3_n)) begin
            assert_select_gate_R1: assert (!op_valid);
        end
    end

    // Output enable high floats the bus.
    always_comb begin
        if (rst_n && oe_n) begin
            assert_oe_float_R10: assert (!q_en && q_out == '0);
        end
    end

    // Sleep silences outputs and blocks accesses.
    always_comb begin
        if (rst_n && sleep) begin
            assert_sleep_quiet_R11: assert (!q_en && !op_valid);
        end
    end

    // Pipelined output valid trails the captured read by one edge.
    assert_pipe_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && !$past(sleep)) |-> (out_v == $past(rd_v)));

    // A flow-through commit was requested exactly one cycle earlier.
    assert_flow_late_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_valid && !pipe_mode) |-> $past(op_valid && op_write));

    // A pipelined commit was requested exactly two cycles earlier.
    assert_pipe_late_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_valid && pipe_mode) |-> $past(op_valid && op_write, 2));

    // Linear continuation steps the low address bits by one.
    assert_linear_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_ilv && op_valid && adv && $past(op_valid))
        |-> (op_addr[1:0] == $past(op_addr[1:0]) + 2'd1));
endmodule

bind nowait_sram nws_checker #(.ADDR_W(ADDR_W), .DATA_W(LANES*BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pipe_mode (pipe_mode),
    .burst_ilv (burst_ilv),
    .ce1_n     (ce1_n),
    .ce2       (ce2),
    .ce3_n     (ce3_n),
    .adv       (adv),
    .sleep     (sleep),
    .oe_n      (oe_n),
    .q_en      (q_en),
    .q_out     (q_out),
    .op_valid  (op_valid),
    .op_write  (op_write),
    .op_addr   (op_addr),
    .rd_v      (rd_v),
    .out_v     (out_v),
    .cm_valid  (cm_valid)
);

// File: tb/tb_nowait_sram.sv
// Directed bench for nowait_sram: one task per scenario, each checking itself.
// Inputs change at the falling edge. Outputs are sampled at the falling edge.
module tb_nowait_sram;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int LN = 4;
    localparam int BW = 9;
    localparam int DW = LN * BW;
    localparam logic [2:0] CE_ON = 3'b010;   // {ce1_n, ce2, ce3_n} all active

    logic          clk = 1'b0;
    logic          rst_n;
    logic          pipe_mode, burst_ilv;
    logic          ce1_n, ce2, ce3_n, adv, we_n, oe_n, sleep;
    logic [LN-1:0] bw_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] d_in;
    logic          q_en;
    logic [DW-1:0] q_out;

    int checks = 0;
    int errors = 0;

    nowait_sram #(.ADDR_W(AW), .LANES(LN), .BYTE_W(BW)) dut (
        .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .burst_ilv(burst_ilv),
        .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .adv(adv), .we_n(we_n),
        .bw_n(bw_n), .addr(addr), .d_in(d_in), .oe_n(oe_n), .sleep(sleep),
        .q_en(q_en), .q_out(q_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return {4{3'b101, a}};
    endfunction

    function automatic logic [AW-1:0] beat_addr(input logic [1:0] s, input logic [1:0] k,
                                                input logic ilv);
        logic [1:0] lo;
        lo = ilv ? (s ^ k) : (s + k);
        return {4'b0100, lo};
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic [2:0] ce, input logic s_adv, input logic s_we_n,
                        input logic [AW-1:0] s_addr, input logic [LN-1:0] s_bw_n,
                        input logic [DW-1:0] s_d);
        {ce1_n, ce2, ce3_n} = ce;
        adv  = s_adv;
        we_n = s_we_n;
        addr = s_addr;
        bw_n = s_bw_n;
        d_in = s_d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic mode, input logic ilv);
        rst_n = 1'b0;
        pipe_mode = mode;
        burst_ilv = ilv;
        {ce1_n, ce2, ce3_n} = 3'b101;
        adv = 0; we_n = 1; bw_n = '1; addr = '0; d_in = '0; oe_n = 0; sleep = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R12: idle outputs after reset; an advance with no burst does nothing.
    task automatic t_reset();
        do_reset(1'b0, 1'b0);
        check("R12 q_en after reset", DW'(q_en), DW'(0));
        check("R12 q_out after reset", q_out, '0);
        step(CE_ON, 1'b1, 1'b1, 6'd0, '1, '0);
        check("R12 adv without burst", DW'(q_en), DW'(0));
    endtask

    // R2 R4 R5: flow-through write/read alternating every cycle.
    task automatic t_flow_rwr();
        do_reset(1'b0, 1'b0);
        step(CE_ON, 0, 0, 6'd3, 4'b0000, '0);
        step(CE_ON, 0, 1, 6'd3, '1, pat(6'd3));
        check("R2 flow read valid", DW'(q_en), DW'(1));
        check("R4 flow late write data", q_out, pat(6'd3));
        step(CE_ON, 0, 0, 6'd4, 4'b0000, '0);
        check("R2 flow data one cycle only", DW'(q_en), DW'(0));
        step(CE_ON, 0, 1, 6'd4, '1, pat(6'd4));
        check("R5 flow W-R-W-R", q_out, pat(6'd4));
    endtask

    // R3 R4 R5 R6: pipelined timing, forwarding, deselect between address and data.
    task automatic t_pipe_rwr();
        do_reset(1'b1, 1'b0);
        step(CE_ON, 0, 0, 6'd5, 4'b0000, '0);
        step(CE_ON, 0, 1, 6'd5, '1, '0);
        check("R3 pipe read not yet out", DW'(q_en), DW'(0));
        step(CE_ON, 0, 0, 6'd6, 4'b0000, pat(6'd5));
        check("R3 pipe read out one edge later", DW'(q_en), DW'(1));
        check("R6 pipe read merges pending write", q_out, pat(6'd5));
        step(3'b110, 0, 1, 6'd0, '1, '0);
        check("R5 pipe write cycle drives nothing", DW'(q_en), DW'(0));
        step(CE_ON, 0, 1, 6'd6, '1, pat(6'd6));
        step(3'b110, 0, 1, 6'd0, '1, '0);
        check("R4 pipe write survives deselect", q_out, pat(6'd6));
    endtask

    // R7: lane-masked write keeps the other lanes.
    task automatic t_bytes();
        do_reset(1'b0, 1'b0);
        step(CE_ON, 0, 0, 6'd7, 4'b0000, '0);
        step(CE_ON, 0, 0, 6'd7, 4'b1110, pat(6'd7));
        step(CE_ON, 0, 1, 6'd7, '1, {27'h0, 9'h1FF});
        check("R7 lane 0 only written", q_out, {pat(6'd7)[DW-1:BW], 9'h1FF});
    endtask

    // R1: each inactive enable blocks a write and a read.
    task automatic t_enables();
        do_reset(1'b0, 1'b0);
        step(CE_ON, 0, 0, 6'd8, 4'b0000, '0);
        step(3'b110, 0, 1, 6'd0, '1, pat(6'd8));
        for (int e = 0; e < 3; e++) begin
            logic [2:0] ce;
            ce = CE_ON ^ (3'b001 << e);
            step(ce, 0, 0, 6'd8, 4'b0000, '0);
            step(3'b110, 0, 1, 6'd0, '1, '0);
        end
        step(3'b000, 0, 1, 6'd8, '1, '0);
        check("R1 read with ce2 low", DW'(q_en), DW'(0));
        step(CE_ON, 0, 1, 6'd8, '1, '0);
        check("R1 deselected writes ignored", q_out, pat(6'd8));
    endtask

    // R10: output enable acts without a clock edge.
    task automatic t_oe();
        oe_n = 1'b1;
        step(CE_ON, 0, 1, 6'd8, '1, '0);
        check("R10 oe_n high q_en", DW'(q_en), DW'(0));
        check("R10 oe_n high q_out", q_out, '0);
        oe_n = 1'b0;
        #1;
        check("R10 oe_n low at once", q_out, pat(6'd8));
        oe_n = 1'b1;
        #1;
        check("R10 oe_n high at once", DW'(q_en), DW'(0));
        oe_n = 1'b0;
    endtask

    // R8 / R9: burst write then single and burst reads.
    task automatic t_burst(input logic ilv);
        string req;
        req = ilv ? "R9 interleaved burst" : "R8 linear burst";
        do_reset(1'b0, ilv);
        step(CE_ON, 0, 0, beat_addr(2'd1, 2'd0, ilv), 4'b0000, '0);
        for (int k = 1; k < 4; k++) begin
            step(CE_ON, 1, 1, 6'd0, 4'b0000, pat(beat_addr(2'd1, 2'(k-1), ilv)));
        end
        step(3'b110, 0, 1, 6'd0, '1, pat(beat_addr(2'd1, 2'd3, ilv)));
        for (int a = 16; a < 20; a++) begin
            step(CE_ON, 0, 1, 6'(a), '1, '0);
            check(req, q_out, pat(6'(a)));
        end
        step(CE_ON, 0, 1, beat_addr(2'd3, 2'd0, ilv), '1, '0);
        check(req, q_out, pat(beat_addr(2'd3, 2'd0, ilv)));
        for (int k = 1; k < 4; k++) begin
            step(CE_ON, 1, 0, 6'd0, '1, '0);
            check(req, q_out, pat(beat_addr(2'd3, 2'(k), ilv)));
        end
    endtask

    // R11: sleep blocks writes and drops outputs at once.
    task automatic t_sleep();
        do_reset(1'b0, 1'b0);
        step(CE_ON, 0, 0, 6'd9, 4'b0000, '0);
        step(3'b110, 0, 1, 6'd0, '1, pat(6'd9));
        sleep = 1'b1;
        step(CE_ON, 0, 0, 6'd9, 4'b0000, '0);
        step(3'b110, 0, 1, 6'd0, '1, '0);
        sleep = 1'b0;
        step(CE_ON, 0, 1, 6'd9, '1, '0);
        check("R11 write during sleep ignored", q_out, pat(6'd9));
        sleep = 1'b1;
        #1;
        check("R11 sleep drops q_en at once", DW'(q_en), DW'(0));
        sleep = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_flow_rwr();
        t_pipe_rwr();
        t_bytes();
        t_enables();
        t_oe();
        t_burst(1'b0);
        t_burst(1'b1);
        t_sleep();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule